// File: doc/BRIEF.md
# Calendar Counter with Deferred Register Writes

This block keeps the time of day and the calendar date in two packed binary words and moves them forward on every pulse of a one-second tick input. Seconds carry into minutes, minutes into hours and hours into the day. The day rolls over at the end of each month, and the month length depends on the month number and on a stored leap flag. The year is a 6-bit count of years since 1970, so it covers 1970 to 2033. When the year advances, the leap flag is recomputed.

Software reaches the block through a simple register port. A write to the time word or the date word does not change the running counter at once. The value waits in a holding register, and a per-word busy flag shows in the control word. On the next second tick the held value replaces the live word and the flag drops. Software polls the busy flags before it starts another write. Reads always return the live words. Because the counter keeps moving, two reads taken on either side of a tick may differ.

Top module: `cal_clock`

## Requirements
- R1: After reset the time word reads 0 (00:00:00), the date word reads 0x00000101 (day 1, month 1, year offset 0, leap flag 0) and the control word reads 0.
- R2: The time word at address 0x14 holds seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. Every other bit reads 0, including bits that were written as 1.
- R3: The date word at address 0x10 holds the day in bits 4:0, the 1-based month in bits 11:8, the year offset from 1970 in bits 21:16 and the leap flag in bit 22. Every other bit reads 0.
- R4: Each tick adds one second. A seconds value at or above 59 becomes 0 and carries into minutes. A minutes value at or above 59 becomes 0 and carries into hours. An hours value at or above 23 becomes 0 and carries one day into the date.
- R5: On a day carry the day becomes 1 and the month advances when the day is at or above the last day of the month; otherwise the day increments. The last day is 30 for months 4, 6, 9 and 11, 29 for month 2 when the leap flag is 1, 28 for month 2 when the flag is 0, and 31 for every other month. A month at or above 12 becomes 1 and carries into the year.
- R6: When the year advances, the year offset 63 wraps to 0. The leap flag becomes 1 exactly when 1970 plus the new offset is divisible by 4, that is when the offset modulo 4 equals 2. The leap flag does not change on a day or month rollover.
- R7: A write to the time word sets control bit 8 from the next cycle on. The live time is unchanged until the commit.
- R8: A write to the date word sets control bit 7 from the next cycle on. The live date is unchanged until the commit.
- R9: On the first tick after a write, the held value is loaded and its busy bit clears at that same clock edge.
  - A time commit loads the time and leaves the date unchanged at that tick.
  - A date commit loads the date while the time advances normally at that tick; any day carry from the time is dropped.
- R10: A write that arrives in the same cycle as a tick defers the commit of that word to the following tick, and the word advances normally at the current tick. Of several writes made before a commit, the last one wins.
- R11: The control word shows the busy bits in bits 8:7. Bit 9 and all other bits read 0. Writes to the control address or to any unmapped address have no effect, and unmapped addresses read 0.
- R12: Without a tick, the time and the date hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse per second |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (8) | Register byte address |
| regWrData | input | DATA_W (32) | Write data |
| regRdData | output | DATA_W (32) | Combinational read data for regAddr |

## Verification
The hardest cases to reach are the collisions between the bus and the tick.

- A write that lands in the exact cycle of a tick.
- A commit of only one of the two words at a moment when the time would carry into the date.

The stimulus drives the write strobe and the tick on the same falling edge to produce the first case. For the second, it first commits 23:59:59, then writes just one word, so that the commit tick and the midnight carry coincide. Month ends, the leap day and the wrap of year 2033 come from a vector table, which loads each start value through the deferred-write path.

// File: rtl/cal_pkg.sv
package cal_pkg;
  // field widths
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 5;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 6;

  // field positions inside the packed words (decoded by software)
  localparam int SEC_LSB  = 0;
  localparam int MIN_LSB  = 8;
  localparam int HOUR_LSB = 16;
  localparam int DAY_LSB  = 0;
  localparam int MON_LSB  = 8;
  localparam int YEAR_LSB = 16;
  localparam int LEAP_BIT = 22;

  // busy flag positions in the control word
  localparam int BUSY_DATE_BIT = 7;
  localparam int BUSY_TIME_BIT = 8;

  // rollover limits
  localparam int SEC_MAX  = 59;
  localparam int MIN_MAX  = 59;
  localparam int HOUR_MAX = 23;
  localparam int MON_MAX  = 12;
  // offset mod 4 at which 1970+offset is a leap year
  localparam int LEAP_PHASE = 2;

  typedef struct packed {
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  minute;
    logic [SEC_W-1:0]  second;
  } timeT;

  typedef struct packed {
    logic              leap;
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  month;
    logic [DAY_W-1:0]  day;
  } dateT;

  typedef struct packed {
    logic captureTime;
    logic captureDate;
    logic commitTime;
    logic commitDate;
    logic advance;
  } strobeT;

  function automatic timeT unpackTime(input logic [31:0] w);
    timeT t;
    t.second = w[SEC_LSB  +: SEC_W];
    t.minute = w[MIN_LSB  +: MIN_W];
    t.hour   = w[HOUR_LSB +: HOUR_W];
    return t;
  endfunction

  function automatic dateT unpackDate(input logic [31:0] w);
    dateT d;
    d.day   = w[DAY_LSB  +: DAY_W];
    d.month = w[MON_LSB  +: MON_W];
    d.year  = w[YEAR_LSB +: YEAR_W];
    d.leap  = w[LEAP_BIT];
    return d;
  endfunction

  function automatic logic [31:0] packTime(input timeT t);
    logic [31:0] w;
    w = '0;
    w[SEC_LSB  +: SEC_W]  = t.second;
    w[MIN_LSB  +: MIN_W]  = t.minute;
    w[HOUR_LSB +: HOUR_W] = t.hour;
    return w;
  endfunction

  function automatic logic [31:0] packDate(input dateT d);
    logic [31:0] w;
    w = '0;
    w[DAY_LSB  +: DAY_W]  = d.day;
    w[MON_LSB  +: MON_W]  = d.month;
    w[YEAR_LSB +: YEAR_W] = d.year;
    w[LEAP_BIT]           = d.leap;
    return w;
  endfunction
endpackage

// File: rtl/cal_month_end.sv
module cal_month_end
  import cal_pkg::*;
(
  input  logic [MON_W-1:0] month,
  input  logic             leap,
  output logic [DAY_W-1:0] lastDay
);
  always_comb begin
    case (month)
      MON_W'(2):  lastDay = leap ? DAY_W'(29) : DAY_W'(28);
      MON_W'(4),
      MON_W'(6),
      MON_W'(9),
      MON_W'(11): lastDay = DAY_W'(30);
      default:    lastDay = DAY_W'(31);
    endcase
  end
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ADDR_DATE = 'h10,
  parameter int ADDR_TIME = 'h14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobeT            strb,
  output logic              busyTime,
  output logic              busyDate
);
  logic wrTime, wrDate;

  assign wrTime = regWrEn && (regAddr == ADDR_W'(ADDR_TIME));
  assign wrDate = regWrEn && (regAddr == ADDR_W'(ADDR_DATE));

  // a write in the tick cycle defers that word's commit (R10)
  always_comb begin
    strb.captureTime = wrTime;
    strb.captureDate = wrDate;
    strb.commitTime  = secTick && busyTime && !wrTime;
    strb.commitDate  = secTick && busyDate && !wrDate;
    strb.advance     = secTick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyTime <= 1'b0;
      busyDate <= 1'b0;
    end else begin
      if (wrTime)               busyTime <= 1'b1;
      else if (strb.commitTime) busyTime <= 1'b0;
      if (wrDate)               busyDate <= 1'b1;
      else if (strb.commitDate) busyDate <= 1'b0;
    end
  end

  a_r7_time_busy_set: assert property (@(posedge clk) disable iff (!rstN)
    wrTime |=> busyTime);
  a_r8_date_busy_set: assert property (@(posedge clk) disable iff (!rstN)
    wrDate |=> busyDate);
  a_r9_time_busy_clear: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && busyTime && !wrTime) |=> !busyTime);
  a_r9_date_busy_clear: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && busyDate && !wrDate) |=> !busyDate);
  a_r12_busy_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!secTick && !regWrEn) |=> ($stable(busyTime) && $stable(busyDate)));
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [DATA_W-1:0] wrData,
  output timeT              curTime,
  output dateT              curDate
);
  localparam timeT TIME_RST = '{hour: '0, minute: '0, second: '0};
  localparam dateT DATE_RST = '{leap: 1'b0, year: '0, month: MON_W'(1), day: DAY_W'(1)};

  timeT pendTime, timeInc;
  dateT pendDate, dateInc;
  logic secWrap, minWrap, hourWrap, dayCarry;
  logic [DAY_W-1:0]  lastDay;
  logic [YEAR_W-1:0] yearNext;
  logic [31:0] wrWord;
  logic unusedWide;

  if (DATA_W >= 32) begin : g_wide
    assign wrWord     = wrData[31:0];
    assign unusedWide = ^wrData;
  end else begin : g_narrow
    assign wrWord     = 32'(wrData);
    assign unusedWide = 1'b0;
  end

  cal_month_end u_monthEnd (
    .month   (curDate.month),
    .leap    (curDate.leap),
    .lastDay (lastDay)
  );

  // time increment with at-or-above rollover
  always_comb begin
    secWrap  = curTime.second >= SEC_W'(SEC_MAX);
    minWrap  = curTime.minute >= MIN_W'(MIN_MAX);
    hourWrap = curTime.hour   >= HOUR_W'(HOUR_MAX);
    dayCarry = secWrap && minWrap && hourWrap;
    timeInc  = curTime;
    if (!secWrap) begin
      timeInc.second = curTime.second + 1'b1;
    end else begin
      timeInc.second = '0;
      if (!minWrap) begin
        timeInc.minute = curTime.minute + 1'b1;
      end else begin
        timeInc.minute = '0;
        timeInc.hour   = hourWrap ? '0 : curTime.hour + 1'b1;
      end
    end
  end

  // date increment, applied only on a day carry
  always_comb begin
    yearNext = curDate.year + 1'b1;
    dateInc  = curDate;
    if (curDate.day < lastDay) begin
      dateInc.day = curDate.day + 1'b1;
    end else begin
      dateInc.day = DAY_W'(1);
      if (curDate.month < MON_W'(MON_MAX)) begin
        dateInc.month = curDate.month + 1'b1;
      end else begin
        dateInc.month = MON_W'(1);
        dateInc.year  = yearNext;
        dateInc.leap  = (yearNext[1:0] == 2'(LEAP_PHASE));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendTime <= TIME_RST;
      pendDate <= DATE_RST;
    end else begin
      if (strb.captureTime) pendTime <= unpackTime(wrWord);
      if (strb.captureDate) pendDate <= unpackDate(wrWord);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTime <= TIME_RST;
      curDate <= DATE_RST;
    end else begin
      if (strb.commitTime)   curTime <= pendTime;
      else if (strb.advance) curTime <= timeInc;
      if (strb.commitDate)
        curDate <= pendDate;
      else if (strb.advance && !strb.commitTime && dayCarry)
        curDate <= dateInc;
    end
  end

  a_r12_time_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> $stable(curTime));
  a_r12_date_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> $stable(curDate));
  a_r4_sec_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.commitTime && curTime.second < SEC_W'(SEC_MAX))
      |=> curTime.second == $past(curTime.second) + 1'b1);
  a_r9_time_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitTime |=> curTime == $past(pendTime));
  a_r9_date_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitDate |=> curDate == $past(pendDate));
  a_r9_date_still_on_time_load: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitTime && !strb.commitDate) |=> $stable(curDate));
  a_r6_leap_follows_year: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.commitDate && !strb.commitTime && dayCarry
       && curDate.month >= MON_W'(MON_MAX) && curDate.day >= lastDay)
      |=> curDate.leap == (curDate.year[1:0] == 2'(LEAP_PHASE)));
  a_r5_day_valid: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.commitTime && !strb.commitDate && dayCarry)
      |=> (curDate.day == DAY_W'(1)) || (curDate.day == $past(curDate.day) + 1'b1));
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_CTRL = 'h00,
  parameter int ADDR_DATE = 'h10,
  parameter int ADDR_TIME = 'h14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);
  strobeT strb;
  logic   busyTime, busyDate;
  timeT   curTime;
  dateT   curDate;
  logic [31:0] ctrlWord, rdWord;

  cal_ctrl #(
    .ADDR_W    (ADDR_W),
    .ADDR_DATE (ADDR_DATE),
    .ADDR_TIME (ADDR_TIME)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .secTick  (secTick),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .strb     (strb),
    .busyTime (busyTime),
    .busyDate (busyDate)
  );

  cal_datapath #(
    .DATA_W (DATA_W)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (regWrData),
    .curTime (curTime),
    .curDate (curDate)
  );

  always_comb begin
    ctrlWord = '0;
    ctrlWord[BUSY_TIME_BIT] = busyTime;
    ctrlWord[BUSY_DATE_BIT] = busyDate;
  end

  always_comb begin
    if (regAddr == ADDR_W'(ADDR_TIME))      rdWord = packTime(curTime);
    else if (regAddr == ADDR_W'(ADDR_DATE)) rdWord = packDate(curDate);
    else if (regAddr == ADDR_W'(ADDR_CTRL)) rdWord = ctrlWord;
    else                                    rdWord = '0;
  end

  assign regRdData = DATA_W'(rdWord);
endmodule

// File: tb/tb_cal_clock.sv
module tb_cal_clock;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00, A_DATE = 8'h10, A_TIME = 8'h14;

  typedef struct packed {
    logic [31:0] tIn;
    logic [31:0] dIn;
    logic [31:0] ticks;
    logic [31:0] tExp;
    logic [31:0] dExp;
  } vecT;

  localparam int NVEC = 12;
  localparam vecT VECS [NVEC] = '{
    '{32'h00000000, 32'h00000101, 32'd1,  32'h00000001, 32'h00000101},
    '{32'h00173B3B, 32'h0001031F, 32'd1,  32'h00000000, 32'h00010401},
    '{32'h00173B3B, 32'h0042021C, 32'd1,  32'h00000000, 32'h0042021D},
    '{32'h00173B3B, 32'h0001021C, 32'd1,  32'h00000000, 32'h00010301},
    '{32'h00173B3B, 32'h00030C1F, 32'd2,  32'h00000001, 32'h00040101},
    '{32'h00173B3B, 32'h00010C1F, 32'd1,  32'h00000000, 32'h00420101},
    '{32'h00173B3B, 32'h003F0C1F, 32'd1,  32'h00000000, 32'h00000101},
    '{32'h000A3B3A, 32'h005E041E, 32'd3,  32'h000B0001, 32'h005E041E},
    '{32'h000C2238, 32'h001D061E, 32'd65, 32'h000C2401, 32'h001D061E},
    '{32'h00173B3B, 32'h005E091E, 32'd1,  32'h00000000, 32'h005E0A01},
    '{32'h00173B3B, 32'h005E071F, 32'd1,  32'h00000000, 32'h005E0801},
    '{32'h00173B3B, 32'h0042021D, 32'd1,  32'h00000000, 32'h00420301}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  int checks = 0;
  int errors = 0;

  cal_clock dut (
    .clk       (clk),
    .rstN      (rstN),
    .secTick   (secTick),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    cyc();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic tick();
    secTick = 1'b1;
    cyc();
    secTick = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [7:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    checks++;
    if (regRdData !== exp) begin
      errors++;
      $display("FAIL %s addr %h actual %h expected %h", req, a, regRdData, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(); cyc();
    rstN = 1'b1;
    cyc();

    // R1 reset state
    expectReg("R1", A_CTRL, 32'h0);
    expectReg("R1", A_TIME, 32'h0);
    expectReg("R1", A_DATE, 32'h00000101);

    // vector table: load through deferred writes, then run ticks
    for (int i = 0; i < NVEC; i++) begin
      writeReg(A_DATE, VECS[i].dIn);
      writeReg(A_TIME, VECS[i].tIn);
      expectReg("R8", A_CTRL, 32'h00000180);
      tick();
      expectReg("R9", A_CTRL, 32'h0);
      expectReg("R2", A_TIME, VECS[i].tIn);
      expectReg("R3", A_DATE, VECS[i].dIn);
      for (int k = 0; k < int'(VECS[i].ticks); k++) tick();
      expectReg("R4", A_TIME, VECS[i].tExp);
      // vectors 4..6 cross a year boundary
      expectReg((i >= 4 && i <= 6) ? "R6" : "R5", A_DATE, VECS[i].dExp);
    end
    // state now: time 0x00000000, date 0x00420301

    // R7 / R12: pending time not visible, nothing moves without a tick
    writeReg(A_TIME, 32'h00050403);
    expectReg("R7", A_CTRL, 32'h00000100);
    expectReg("R7", A_TIME, 32'h0);
    cyc(); cyc(); cyc();
    expectReg("R12", A_TIME, 32'h0);
    expectReg("R12", A_DATE, 32'h00420301);
    tick();
    expectReg("R9", A_TIME, 32'h00050403);
    expectReg("R9", A_CTRL, 32'h0);

    // R10: last write wins, and a write in the tick cycle defers the commit
    writeReg(A_TIME, 32'h00010000);
    writeReg(A_TIME, 32'h00020000);
    secTick = 1'b1; regWrEn = 1'b1; regAddr = A_TIME; regWrData = 32'h00030000;
    cyc();
    secTick = 1'b0; regWrEn = 1'b0; regWrData = '0;
    expectReg("R10", A_TIME, 32'h00050404);
    expectReg("R10", A_CTRL, 32'h00000100);
    tick();
    expectReg("R10", A_TIME, 32'h00030000);

    // R9: time commit at midnight leaves the date alone
    writeReg(A_TIME, 32'h00173B3B);
    tick();
    writeReg(A_TIME, 32'h00050000);
    tick();
    expectReg("R9", A_TIME, 32'h00050000);
    expectReg("R9", A_DATE, 32'h00420301);

    // R9: date commit at midnight drops the carry, time still advances
    writeReg(A_TIME, 32'h00173B3B);
    tick();
    writeReg(A_DATE, 32'h00010101);
    tick();
    expectReg("R9", A_DATE, 32'h00010101);
    expectReg("R9", A_TIME, 32'h0);

    // R11: control and unmapped writes do nothing
    writeReg(A_CTRL, 32'hFFFFFFFF);
    writeReg(8'h20, 32'hFFFFFFFF);
    expectReg("R11", A_CTRL, 32'h0);
    expectReg("R11", 8'h20, 32'h0);
    expectReg("R11", A_TIME, 32'h0);
    expectReg("R11", A_DATE, 32'h00010101);

    // R2 / R4: reserved bits dropped, out-of-range fields roll over
    writeReg(A_TIME, 32'hFFFFFFFF);
    tick();
    expectReg("R2", A_TIME, 32'h001F3F3F);
    tick();
    expectReg("R4", A_TIME, 32'h0);
    expectReg("R4", A_DATE, 32'h00010102);

    // R3: reserved date bits dropped
    writeReg(A_DATE, 32'hFFFFFFFF);
    tick();
    expectReg("R3", A_DATE, 32'h007F0F1F);
    expectReg("R3", A_TIME, 32'h00000001);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule